// File: doc/BRIEF.md
# Configurable-Register Simple Dual-Port RAM

This block is a parameterized memory with one write port and one read port. Each input group can be passed straight through or captured by a register: the write data, write address, write enable, read address and read enable. The read data output can also be registered. Each register chooses its clock at elaboration time, either the input clock or the output clock, and each clock has its own clock enable. A per-register option decides whether the active-low asynchronous clear resets that register. The clear never touches the stored words, and the array starts out all zeros.

The array is written on a rising input-clock edge. An unregistered write group feeds that edge directly. A registered group adds one capture stage, which is qualified by the input clock enable. When the read enable is low, the read data keeps the last word that was read. A read from an address at or above the configured depth returns zero, and a write to such an address is dropped. The depth may be smaller than two to the power of the address width, but it must exceed half of that. Parameter sets that break this rule, or that put a group on a clock it cannot use, stop elaboration.

Top module: `cfg_dp_ram`

## Requirements
- R1: An active-low `rst_ni` clears at once every register whose clear option is set. In the default and output-registered settings this drives `rd_data_o` to zero. Stored words are kept through the clear.
- R2: The array takes the effective write data at the effective write address on a rising `in_clk_i` edge, and only when `in_ce_i` is high and the effective write enable is high. A registered write group delays the write by one `in_ce_i`-qualified input-clock edge.
- R3: A read address or read enable registered on the output clock captures only on rising `out_clk_i` edges where `out_ce_i` is high. While `out_ce_i` is low, the value it holds does not change.
- R4: With the output registered on `out_clk_i`, `rd_data_o` takes the addressed word on a rising edge where `out_ce_i` and the effective read enable are both high. In every other case it holds its value.
- R5: With the output unregistered, `rd_data_o` shows the word at the effective read address while the effective read enable is high. While that enable is low, `rd_data_o` shows the word captured at the last output-clock edge that had both `out_ce_i` and the read enable high.
- R6: A read and a write to the same address at the same clock edge return the contents as they were before the write.
- R7: A read of an address equal to or above `DEPTH` returns zero. A write to such an address leaves every stored word unchanged.
- R8: By default, `DEPTH` is 2^`ADDR_W`. The three write groups are registered on the input clock, the read address and read enable are registered on the output clock, the output is unregistered, and every register clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk_i | input | 1 | Input clock; clocks the array write and any input-clock register |
| out_clk_i | input | 1 | Output clock; clocks output-clock registers and the read capture |
| rst_ni | input | 1 | Active-low asynchronous clear for registers that select it |
| in_ce_i | input | 1 | Clock enable for the input clock |
| out_ce_i | input | 1 | Clock enable for the output clock |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read enable; low holds the last read word |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data |

## Verification
If a stage register captures while its clock enable is low, `rd_data_o` moves away from the expected word at the next enabled read. With the unregistered output this happens in the same cycle. A write that lands one edge early or late, or lands at an out-of-range address, changes a word in the array. That error shows at the first later read of the address, and the random phase goes back to each address many times. A hold register that is not cleared, or that is wrongly loaded, shows as a wrong value as soon as the read enable drops. A clear that reaches the array shows at the first read after reset that should return earlier data.

// File: rtl/cdpr_pkg.sv
package cdpr_pkg;
  // Clock source of a port register; COMB means no register.
  typedef enum logic [1:0] {
    CDPR_COMB   = 2'd0,
    CDPR_INCLK  = 2'd1,
    CDPR_OUTCLK = 2'd2
  } cdpr_src_e;
endpackage

// File: rtl/cdpr_stage.sv
module cdpr_stage
  import cdpr_pkg::*;
#(
  parameter int unsigned W   = 1,
  parameter cdpr_src_e   SRC = CDPR_COMB,
  parameter bit          CLR = 1'b1
) (
  input  logic         in_clk_i,
  input  logic         out_clk_i,
  input  logic         rst_ni,
  input  logic         in_ce_i,
  input  logic         out_ce_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic unused_pins;
  assign unused_pins = ^{in_clk_i, out_clk_i, in_ce_i, out_ce_i, rst_ni};

  if (SRC == CDPR_COMB) begin : g_pass
    assign q_o = d_i;
  end else begin : g_reg
    logic         clk;
    logic         ce;
    logic [W-1:0] q_q;
    if (SRC == CDPR_INCLK) begin : g_in
      assign clk = in_clk_i;
      assign ce  = in_ce_i;
    end else begin : g_out
      assign clk = out_clk_i;
      assign ce  = out_ce_i;
    end
    if (CLR) begin : g_clr
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)  q_q <= '0;
        else if (ce)  q_q <= d_i;
      end
    end else begin : g_noclr
      always_ff @(posedge clk) begin
        if (ce) q_q <= d_i;
      end
    end
    assign q_o = q_q;
  end
endmodule

// File: rtl/cdpr_array.sv
module cdpr_array #(
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 4,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          ce_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rword_o
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic         w_in_range;
  logic         r_in_range;

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) mem[i] = '0;
  end

  assign w_in_range = {1'b0, waddr_i} < DEPTH_L;
  assign r_in_range = {1'b0, raddr_i} < DEPTH_L;

  always_ff @(posedge clk_i) begin
    if (ce_i && we_i && w_in_range) mem[waddr_i] <= wdata_i;
  end

  // Reads see pre-edge contents: read-before-write at a shared edge.
  assign rword_o = r_in_range ? mem[raddr_i] : '0;
endmodule

// File: rtl/cdpr_rdout.sv
module cdpr_rdout
  import cdpr_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter cdpr_src_e   OSRC = CDPR_COMB,
  parameter bit          CLR  = 1'b1
) (
  input  logic         out_clk_i,
  input  logic         out_ce_i,
  input  logic         rst_ni,
  input  logic         ren_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] cap_q;
  logic         load;

  assign load = out_ce_i && ren_i;

  if (CLR) begin : g_clr
    always_ff @(posedge out_clk_i or negedge rst_ni) begin
      if (!rst_ni)   cap_q <= '0;
      else if (load) cap_q <= word_i;
    end
  end else begin : g_noclr
    always_ff @(posedge out_clk_i) begin
      if (load) cap_q <= word_i;
    end
  end

  if (OSRC == CDPR_OUTCLK) begin : g_reg_out
    assign q_o = cap_q;
  end else begin : g_comb_out
    // cap_q acts as the hold register for a disabled read.
    assign q_o = ren_i ? word_i : cap_q;
  end
endmodule

// File: rtl/cfg_dp_ram.sv
module cfg_dp_ram
  import cdpr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DEPTH     = 2**ADDR_W,
  parameter cdpr_src_e   WDATA_SRC = CDPR_INCLK,
  parameter cdpr_src_e   WADDR_SRC = CDPR_INCLK,
  parameter cdpr_src_e   WEN_SRC   = CDPR_INCLK,
  parameter cdpr_src_e   RADDR_SRC = CDPR_OUTCLK,
  parameter cdpr_src_e   REN_SRC   = CDPR_OUTCLK,
  parameter cdpr_src_e   OUT_SRC   = CDPR_COMB,
  parameter bit          WDATA_CLR = 1'b1,
  parameter bit          WADDR_CLR = 1'b1,
  parameter bit          WEN_CLR   = 1'b1,
  parameter bit          RADDR_CLR = 1'b1,
  parameter bit          REN_CLR   = 1'b1,
  parameter bit          OUT_CLR   = 1'b1
) (
  input  logic              in_clk_i,
  input  logic              out_clk_i,
  input  logic              rst_ni,
  input  logic              in_ce_i,
  input  logic              out_ce_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam longint unsigned FULL = 64'd1 << ADDR_W;
  localparam longint unsigned HALF = FULL >> 1;

  if (ADDR_W < 1 || ADDR_W > 30 || DATA_W < 1) begin : g_bad_width
    $error("cfg_dp_ram: unsupported width");
  end
  if (longint'(DEPTH) <= HALF || longint'(DEPTH) > FULL) begin : g_bad_depth
    $error("cfg_dp_ram: DEPTH outside legal range");
  end
  if (WDATA_SRC == CDPR_OUTCLK || WADDR_SRC == CDPR_OUTCLK ||
      WEN_SRC == CDPR_OUTCLK) begin : g_bad_wr_src
    $error("cfg_dp_ram: write groups may only use the input clock");
  end
  if (OUT_SRC == CDPR_INCLK) begin : g_bad_out_src
    $error("cfg_dp_ram: output may only use the output clock");
  end

  logic [DATA_W-1:0] wdata_eff;
  logic [ADDR_W-1:0] waddr_eff;
  logic              wen_eff;
  logic [ADDR_W-1:0] raddr_eff;
  logic              ren_eff;
  logic [DATA_W-1:0] rword;

  cdpr_stage #(.W(DATA_W), .SRC(WDATA_SRC), .CLR(WDATA_CLR)) u_wdata (
    .in_clk_i, .out_clk_i, .rst_ni, .in_ce_i, .out_ce_i,
    .d_i(wr_data_i), .q_o(wdata_eff)
  );
  cdpr_stage #(.W(ADDR_W), .SRC(WADDR_SRC), .CLR(WADDR_CLR)) u_waddr (
    .in_clk_i, .out_clk_i, .rst_ni, .in_ce_i, .out_ce_i,
    .d_i(wr_addr_i), .q_o(waddr_eff)
  );
  cdpr_stage #(.W(1), .SRC(WEN_SRC), .CLR(WEN_CLR)) u_wen (
    .in_clk_i, .out_clk_i, .rst_ni, .in_ce_i, .out_ce_i,
    .d_i(wr_en_i), .q_o(wen_eff)
  );
  cdpr_stage #(.W(ADDR_W), .SRC(RADDR_SRC), .CLR(RADDR_CLR)) u_raddr (
    .in_clk_i, .out_clk_i, .rst_ni, .in_ce_i, .out_ce_i,
    .d_i(rd_addr_i), .q_o(raddr_eff)
  );
  cdpr_stage #(.W(1), .SRC(REN_SRC), .CLR(REN_CLR)) u_ren (
    .in_clk_i, .out_clk_i, .rst_ni, .in_ce_i, .out_ce_i,
    .d_i(rd_en_i), .q_o(ren_eff)
  );

  cdpr_array #(.W(DATA_W), .AW(ADDR_W), .DEPTH(DEPTH)) u_array (
    .clk_i   (in_clk_i),
    .ce_i    (in_ce_i),
    .we_i    (wen_eff),
    .waddr_i (waddr_eff),
    .wdata_i (wdata_eff),
    .raddr_i (raddr_eff),
    .rword_o (rword)
  );

  cdpr_rdout #(.W(DATA_W), .OSRC(OUT_SRC), .CLR(OUT_CLR)) u_rdout (
    .out_clk_i,
    .out_ce_i,
    .rst_ni,
    .ren_i  (ren_eff),
    .word_i (rword),
    .q_o    (rd_data_o)
  );
endmodule

// File: rtl/cfg_dp_ram_chk.sv
module cfg_dp_ram_chk
  import cdpr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DEPTH     = 16,
  parameter cdpr_src_e   RADDR_SRC = CDPR_OUTCLK,
  parameter cdpr_src_e   REN_SRC   = CDPR_OUTCLK,
  parameter cdpr_src_e   OUT_SRC   = CDPR_COMB,
  parameter bit          REN_CLR   = 1'b1,
  parameter bit          OUT_CLR   = 1'b1
) (
  input logic              out_clk_i,
  input logic              rst_ni,
  input logic              out_ce_i,
  input logic              ren_eff,
  input logic [ADDR_W-1:0] raddr_eff,
  input logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(DEPTH);
  localparam bit Q_CLEARS = (OUT_SRC == CDPR_OUTCLK) ? OUT_CLR
                          : (OUT_CLR && REN_CLR && REN_SRC != CDPR_COMB);

  logic oob;
  assign oob = {1'b0, raddr_eff} >= DEPTH_L;

  if (Q_CLEARS) begin : g_clr
    p_clear_zero_r1: assert property (@(posedge out_clk_i)
      !rst_ni |-> rd_data_o == '0);
  end

  if (REN_SRC == CDPR_OUTCLK) begin : g_ren_gate
    p_ren_gate_r3: assert property (@(posedge out_clk_i) disable iff (!rst_ni)
      !out_ce_i |=> $stable(ren_eff));
  end
  if (RADDR_SRC == CDPR_OUTCLK) begin : g_raddr_gate
    p_raddr_gate_r3: assert property (@(posedge out_clk_i) disable iff (!rst_ni)
      !out_ce_i |=> $stable(raddr_eff));
  end

  if (OUT_SRC == CDPR_OUTCLK) begin : g_reg_out
    p_q_hold_r4: assert property (@(posedge out_clk_i) disable iff (!rst_ni)
      !(out_ce_i && ren_eff) |=> $stable(rd_data_o));
    p_oob_zero_r7: assert property (@(posedge out_clk_i) disable iff (!rst_ni)
      (out_ce_i && ren_eff && oob) |=> rd_data_o == '0);
  end else begin : g_comb_out
    p_q_hold_r5: assert property (@(posedge out_clk_i) disable iff (!rst_ni)
      (!ren_eff && $past(!ren_eff)) |-> $stable(rd_data_o));
    p_oob_zero_r7: assert property (@(posedge out_clk_i) disable iff (!rst_ni)
      (ren_eff && oob) |-> rd_data_o == '0);
  end
endmodule

bind cfg_dp_ram cfg_dp_ram_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH),
  .RADDR_SRC(RADDR_SRC), .REN_SRC(REN_SRC), .OUT_SRC(OUT_SRC),
  .REN_CLR(REN_CLR), .OUT_CLR(OUT_CLR)
) u_chk (
  .out_clk_i (out_clk_i),
  .rst_ni    (rst_ni),
  .out_ce_i  (out_ce_i),
  .ren_eff   (ren_eff),
  .raddr_eff (raddr_eff),
  .rd_data_o (rd_data_o)
);

// File: tb/cfg_dp_ram_bench.sv
module cfg_dp_ram_bench;
  import cdpr_pkg::*;

  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DB    = 12;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          ice, oce, we, re;
  logic [AW-1:0] wa, ra;
  logic [DW-1:0] wd;
  logic [DW-1:0] q_a, q_b;

  int n_chk = 0;
  int n_bad = 0;

  // model state: instance A (defaults), instance B (comb inputs, reg output)
  logic [DW-1:0] ma [16];
  logic [DW-1:0] mb [16];
  logic [DW-1:0] wd_r, hold_a, qb;
  logic [AW-1:0] wa_r, ra_r;
  logic          we_r, re_r;

  always #(CLK_P/2) clk = ~clk;

  // R8: all defaults
  cfg_dp_ram #(.DATA_W(DW), .ADDR_W(AW)) u_cfg_dp_ram (
    .in_clk_i(clk), .out_clk_i(clk), .rst_ni(rst_ni),
    .in_ce_i(ice), .out_ce_i(oce),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_en_i(re), .rd_addr_i(ra), .rd_data_o(q_a)
  );

  cfg_dp_ram #(
    .DATA_W(DW), .ADDR_W(AW), .DEPTH(DB),
    .WDATA_SRC(CDPR_COMB), .WADDR_SRC(CDPR_COMB), .WEN_SRC(CDPR_COMB),
    .RADDR_SRC(CDPR_COMB), .REN_SRC(CDPR_COMB), .OUT_SRC(CDPR_OUTCLK)
  ) u_cfg_dp_ram_b (
    .in_clk_i(clk), .out_clk_i(clk), .rst_ni(rst_ni),
    .in_ce_i(ice), .out_ce_i(oce),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_en_i(re), .rd_addr_i(ra), .rd_data_o(q_b)
  );

  function automatic logic [DW-1:0] exp_a();
    return re_r ? ma[ra_r] : hold_a;
  endfunction

  task automatic clear_model();
    wd_r = '0; wa_r = '0; we_r = 1'b0; ra_r = '0; re_r = 1'b0;
    hold_a = '0; qb = '0;
  endtask

  task automatic compare(input string req);
    logic [DW-1:0] ea;
    ea = exp_a();
    n_chk += 2;
    if (q_a !== ea) begin
      n_bad++;
      $display("FAIL %s inst A: actual=%h expected=%h", req, q_a, ea);
    end
    if (q_b !== qb) begin
      n_bad++;
      $display("FAIL %s inst B: actual=%h expected=%h", req, q_b, qb);
    end
  endtask

  task automatic drive(input logic i_ce, input logic o_ce, input logic w_en,
                       input logic [AW-1:0] w_a, input logic [DW-1:0] w_d,
                       input logic r_en, input logic [AW-1:0] r_a);
    ice = i_ce; oce = o_ce; we = w_en; wa = w_a; wd = w_d; re = r_en; ra = r_a;
  endtask

  task automatic tick(input string req);
    logic [DW-1:0] rda, rdb;
    @(posedge clk);
    rda = ma[ra_r];
    rdb = (int'(ra) < DB) ? mb[ra] : '0;
    if (ice && we_r) ma[wa_r] = wd_r;
    if (oce && re_r) hold_a = rda;
    if (ice) begin wd_r = wd; wa_r = wa; we_r = we; end
    if (oce) begin ra_r = ra; re_r = re; end
    if (ice && we && int'(wa) < DB) mb[wa] = wd;
    if (oce && re) qb = rdb;
    @(negedge clk);
    compare(req);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) begin ma[i] = '0; mb[i] = '0; end
    clear_model();
    rst_ni = 1'b0;
    drive(1'b1, 1'b1, 1'b0, '0, '0, 1'b0, '0);
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;

    // R2: write, then gated writes that must not land
    drive(1, 1, 1, 4'd3, 8'hA5, 0, 4'd0); tick("R2");
    drive(1, 1, 0, 4'd3, 8'h00, 0, 4'd0); tick("R2");
    drive(0, 1, 1, 4'd3, 8'hFF, 1, 4'd3); tick("R2");
    drive(1, 1, 0, 4'd0, 8'h00, 1, 4'd3); tick("R2");
    drive(1, 1, 0, 4'd0, 8'h00, 1, 4'd3); tick("R2");

    // R6: same address read and write at one edge
    drive(1, 1, 1, 4'd5, 8'h11, 0, 4'd5); tick("R6");
    drive(1, 1, 1, 4'd5, 8'h22, 1, 4'd5); tick("R6");
    drive(1, 1, 0, 4'd5, 8'h00, 1, 4'd5); tick("R6");
    drive(1, 1, 0, 4'd5, 8'h00, 1, 4'd5); tick("R6");

    // R7: address beyond depth on instance B
    drive(1, 1, 1, 4'd13, 8'h3C, 0, 4'd0); tick("R7");
    drive(1, 1, 0, 4'd13, 8'h00, 1, 4'd13); tick("R7");
    drive(1, 1, 0, 4'd13, 8'h00, 1, 4'd13); tick("R7");

    // R4 R5: read disabled, address moving
    for (int i = 0; i < 5; i++) begin
      drive(1, 1, 0, 4'd0, 8'h00, 0, 4'(i + 2)); tick("R4 R5");
    end

    // R3: output clock enable low
    for (int i = 0; i < 3; i++) begin
      drive(1, 0, 0, 4'd0, 8'h00, 1, 4'(i + 7)); tick("R3");
    end

    // R8: random traffic on the default configuration
    for (int i = 0; i < 800; i++) begin
      drive(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 2) != 0,
            AW'($urandom), DW'($urandom), ($urandom % 3) != 0, AW'($urandom));
      tick("R8");
    end

    // R1: clear mid-run, contents must survive
    drive(1, 1, 0, 4'd0, 8'h00, 1, 4'd3);
    rst_ni = 1'b0;
    #1;
    clear_model();
    compare("R1");
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    drive(1, 1, 0, 4'd0, 8'h00, 1, 4'd3); tick("R1");
    drive(1, 1, 0, 4'd0, 8'h00, 1, 4'd3); tick("R1");
    drive(1, 1, 0, 4'd0, 8'h00, 1, 4'd5); tick("R1");
    drive(1, 1, 0, 4'd0, 8'h00, 1, 4'd5); tick("R1");

    summary();
    $finish;
  end
endmodule